// File: doc/BRIEF.md
# Ownership Snooping Cache Controller

This block is the cache controller of one processor in a shared-bus multiprocessor. It holds a direct-mapped array of one-word lines, each tagged INVALID, CLEAN or DIRTY. Lines that several processors read stay CLEAN in every cache that holds them. A line that one processor writes becomes DIRTY in that cache alone, so later writes to it stay off the bus until another processor asks for the word.

The controller watches every bus access made by the other processors. If it holds the addressed word DIRTY, it supplies the word itself and raises a memory-inhibit output in the same cycle. It then drops its copy, and the requester becomes the new owner. A DIRTY line that loses its slot to another address is written back before the slot is reused. A CLEAN line is simply overwritten.

The processor holds its request (`cpuReq`, `cpuWe`, `cpuAddr`, `cpuWdata`) stable until `cpuDone` pulses. The bus side raises `busReq` and treats any cycle in which `busReq` and `busAck` are both high as one completed word transfer.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is INVALID, so the first read of any address goes to the bus. `busReq`, `cpuDone` and `snpInhibit` are low while the processor and snoop inputs are idle.
- R2: A line's slot is `addr[IDX_W-1:0]` and its tag is the remaining upper address bits. A read miss performs one bus read and installs the word CLEAN. A read hit returns the cached word with no bus transfer.
- R3: A snooped read of an address held CLEAN, or of an address not held, leaves `snpInhibit` low and keeps the line unchanged.
- R4: A local write to a line that is not DIRTY (a CLEAN hit or a miss) performs one bus write of `cpuWdata` to `cpuAddr` and leaves the line DIRTY with the new word.
- R5: A local write to a DIRTY line completes with no bus transfer, and a later read returns the new word.
- R6: A snooped read or write that hits a DIRTY line raises `snpInhibit` in the same cycle, with `snpData` equal to the cached word. The line becomes INVALID, so the next local access to it misses.
- R7: A snooped write that hits a CLEAN line invalidates it without raising `snpInhibit`.
- R8: A fill completed with `busFromCache` high installs the word DIRTY, so a following local write needs no bus transfer.
- R9: A miss whose slot holds a DIRTY line for another address first writes that line's word back to its own address. Only then does it perform the fill or the write.
- R10: A miss whose slot holds a CLEAN line for another address replaces it with no bus write.
- R11: In any cycle in which a snoop hits a DIRTY line, `busReq` is low. If that snoop takes away the line that was waiting to be written back, the write-back is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access request, held until done |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | DATA_W | Processor write word |
| cpuRdata | output | DATA_W | Read word, valid with cpuDone |
| cpuDone | output | 1 | Access completes at this clock edge |
| busReq | output | 1 | Bus transfer requested |
| busWr | output | 1 | 1 = bus write, 0 = bus read |
| busAddr | output | ADDR_W | Bus transfer address |
| busWdata | output | DATA_W | Bus write word |
| busAck | input | 1 | Transfer completes this cycle |
| busRdata | input | DATA_W | Bus read word |
| busFromCache | input | 1 | Read word comes from another cache's DIRTY copy |
| snpValid | input | 1 | Another processor's bus access is visible |
| snpWr | input | 1 | Snooped access is a write |
| snpAddr | input | ADDR_W | Snooped address |
| snpInhibit | output | 1 | Memory must not answer; this cache supplies the word |
| snpData | output | DATA_W | Word supplied on a DIRTY snoop hit |

## Verification
The bench builds the controller with ADDR_W=6, DATA_W=8 and IDX_W=2, which gives four slots and a 4-bit tag. Addresses such as 0x04 and 0x08 therefore share a slot. This lets a short sequence reach DIRTY and CLEAN evictions, write-back ordering, and a snoop that takes a victim while its write-back is still pending. The bench's memory answers each bus request in the same cycle and counts reads and writes, so every access can be checked for the exact number of transfers the protocol allows.

// File: rtl/snc_pkg.sv
`timescale 1ns/1ps
package snc_pkg;

  typedef enum logic [1:0] {
    LN_INVALID = 2'd0,
    LN_CLEAN   = 2'd1,
    LN_DIRTY   = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hitWrite;    // overwrite a DIRTY hit locally
    logic fillLine;    // install bus read word
    logic writeLine;   // install processor word as DIRTY
    logic dropVictim;  // victim written back, release slot
  } ctrlStrb_t;

endpackage

// File: rtl/snc_datapath.sv
`timescale 1ns/1ps
module snc_datapath
  import snc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busFromCache,
  input  logic              snpValid,
  input  logic              snpWr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  ctrlStrb_t         strb,
  output logic              cpuHit,
  output logic              cpuHitDirty,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] victimData,
  output logic [DATA_W-1:0] hitData,
  output logic              snpHitDirty,
  output logic [DATA_W-1:0] snpData
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stateArr [LINES];
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  lineState_t       cpuSt, snpSt;
  logic             snpHit, snpKill;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign cpuSt = stateArr[cpuIdx];
  assign snpSt = stateArr[snpIdx];

  always_comb begin
    cpuHit      = (cpuSt != LN_INVALID) && (tagArr[cpuIdx] == cpuTag);
    cpuHitDirty = cpuHit && (cpuSt == LN_DIRTY);
    victimDirty = (cpuSt == LN_DIRTY) && (tagArr[cpuIdx] != cpuTag);
    victimAddr  = {tagArr[cpuIdx], cpuIdx};
    victimData  = dataArr[cpuIdx];
    hitData     = dataArr[cpuIdx];
    snpHit      = snpValid && (snpSt != LN_INVALID) && (tagArr[snpIdx] == snpTag);
    snpHitDirty = snpHit && (snpSt == LN_DIRTY);
    snpKill     = snpHit && (snpWr || (snpSt == LN_DIRTY));
    snpData     = snpHitDirty ? dataArr[snpIdx] : '0;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    lineState_t        st;
    logic [TAG_W-1:0]  tg;
    logic [DATA_W-1:0] dt;
    logic              cpuSel, snpSel;

    assign cpuSel = (cpuIdx == IDX_W'(i));
    assign snpSel = (snpIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= LN_INVALID;
        tg <= '0;
        dt <= '0;
      end else begin
        if (snpSel && snpKill) st <= LN_INVALID;
        if (cpuSel) begin
          if (strb.hitWrite)   dt <= cpuWdata;
          if (strb.dropVictim) st <= LN_INVALID;
          if (strb.fillLine) begin
            tg <= cpuTag;
            dt <= busRdata;
            st <= busFromCache ? LN_DIRTY : LN_CLEAN;
          end
          if (strb.writeLine) begin
            tg <= cpuTag;
            dt <= cpuWdata;
            st <= LN_DIRTY;
          end
        end
      end
    end

    assign stateArr[i] = st;
    assign tagArr[i]   = tg;
    assign dataArr[i]  = dt;
  end

endmodule

// File: rtl/snc_control.sv
`timescale 1ns/1ps
module snc_control
  import snc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      snpValid,
  input  logic      snpHitDirty,
  input  logic      cpuHit,
  input  logic      cpuHitDirty,
  input  logic      victimDirty,
  input  logic      busAck,
  output ctrlStrb_t strb,
  output logic      cpuDone,
  output logic      busReq,
  output logic      busWr,
  output logic      busSelVictim
);

  ctrlState_t curSt, nxtSt;
  ctrlState_t missSt;

  assign missSt = cpuWe ? ST_WRITE : ST_FILL;

  always_comb begin
    nxtSt        = curSt;
    strb         = '0;
    cpuDone      = 1'b0;
    busReq       = 1'b0;
    busWr        = 1'b0;
    busSelVictim = 1'b0;
    unique case (curSt)
      ST_IDLE: begin
        // snoops own the array in their cycle; processor waits
        if (cpuReq && !snpValid) begin
          if (cpuHit && !cpuWe) begin
            cpuDone = 1'b1;
          end else if (cpuHitDirty && cpuWe) begin
            strb.hitWrite = 1'b1;
            cpuDone       = 1'b1;
          end else if (victimDirty) begin
            nxtSt = ST_WBACK;
          end else begin
            nxtSt = missSt;
          end
        end
      end
      ST_WBACK: begin
        if (!victimDirty) begin
          nxtSt = missSt;                 // victim taken by a snoop
        end else if (!snpHitDirty) begin
          busReq       = 1'b1;
          busWr        = 1'b1;
          busSelVictim = 1'b1;
          if (busAck) begin
            strb.dropVictim = 1'b1;
            nxtSt           = missSt;
          end
        end
      end
      ST_FILL: begin
        if (!snpHitDirty) begin
          busReq = 1'b1;
          if (busAck) begin
            strb.fillLine = 1'b1;
            cpuDone       = 1'b1;
            nxtSt         = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (!snpHitDirty) begin
          busReq = 1'b1;
          busWr  = 1'b1;
          if (busAck) begin
            strb.writeLine = 1'b1;
            cpuDone        = 1'b1;
            nxtSt          = ST_IDLE;
          end
        end
      end
      default: nxtSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSt <= ST_IDLE;
    else       curSt <= nxtSt;
  end

endmodule

// File: rtl/snoop_cache.sv
`timescale 1ns/1ps
module snoop_cache
  import snc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busFromCache,
  input  logic              snpValid,
  input  logic              snpWr,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpInhibit,
  output logic [DATA_W-1:0] snpData
);

  ctrlStrb_t         strb;
  logic              cpuHit, cpuHitDirty, victimDirty, snpHitDirty, busSelVictim;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] victimData, hitData;

  snc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busRdata(busRdata), .busFromCache(busFromCache),
    .snpValid(snpValid), .snpWr(snpWr), .snpAddr(snpAddr),
    .strb(strb),
    .cpuHit(cpuHit), .cpuHitDirty(cpuHitDirty), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .victimData(victimData), .hitData(hitData),
    .snpHitDirty(snpHitDirty), .snpData(snpData)
  );

  snc_control u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe),
    .snpValid(snpValid), .snpHitDirty(snpHitDirty),
    .cpuHit(cpuHit), .cpuHitDirty(cpuHitDirty), .victimDirty(victimDirty),
    .busAck(busAck),
    .strb(strb), .cpuDone(cpuDone),
    .busReq(busReq), .busWr(busWr), .busSelVictim(busSelVictim)
  );

  assign snpInhibit = snpHitDirty;
  assign busAddr    = busSelVictim ? victimAddr : cpuAddr;
  assign busWdata   = busSelVictim ? victimData : cpuWdata;
  assign cpuRdata   = strb.fillLine ? busRdata : hitData;

endmodule

// File: rtl/snc_checker.sv
`timescale 1ns/1ps
module snc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuDone,
  input logic              busReq,
  input logic              snpValid,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpInhibit
);

  // R11
  inhibit_blocks_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpInhibit |-> !busReq);

  // R6
  inhibit_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpInhibit |-> snpValid);

  // R6
  owner_gives_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpInhibit |=> !(snpInhibit && (snpAddr == $past(snpAddr))));

  // R4 R5
  writer_owns_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuWe) |=> (!(snpValid && (snpAddr == $past(cpuAddr))) || snpInhibit));

  // R2
  bus_only_for_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> cpuReq);

  // R1
  done_only_for_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq);

endmodule

bind snoop_cache snc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuDone(cpuDone), .busReq(busReq), .snpValid(snpValid), .snpAddr(snpAddr),
  .snpInhibit(snpInhibit)
);

// File: tb/snoop_cache_tb.sv
`timescale 1ns/1ps
module snoop_cache_tb;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SRD = 2'd2, OP_SWR = 2'd3;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;     // write word, or word supplied by a remote cache
    logic          fromC;
    logic [DW-1:0] expData;  // read word, or snpData when inhibit expected
    logic          expFlag;  // expected snpInhibit for snoops
    logic [1:0]    expWr;
    logic [1:0]    expRd;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  6'h04, 8'h00, 1'b0, 8'h5E, 1'b0, 2'd0, 2'd1, 4'd2},  // R2 miss
    '{OP_RD,  6'h04, 8'h00, 1'b0, 8'h5E, 1'b0, 2'd0, 2'd0, 4'd2},  // R2 hit
    '{OP_SRD, 6'h04, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd3},  // R3 clean
    '{OP_WR,  6'h04, 8'h11, 1'b0, 8'h00, 1'b0, 2'd1, 2'd0, 4'd4},  // R4
    '{OP_WR,  6'h04, 8'h22, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd5},  // R5
    '{OP_RD,  6'h04, 8'h00, 1'b0, 8'h22, 1'b0, 2'd0, 2'd0, 4'd5},  // R5
    '{OP_SRD, 6'h04, 8'h00, 1'b0, 8'h22, 1'b1, 2'd0, 2'd0, 4'd6},  // R6 read
    '{OP_RD,  6'h04, 8'h77, 1'b1, 8'h77, 1'b0, 2'd0, 2'd1, 4'd8},  // R8
    '{OP_WR,  6'h04, 8'h78, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd8},  // R8
    '{OP_RD,  6'h08, 8'h00, 1'b0, 8'h52, 1'b0, 2'd1, 2'd1, 4'd9},  // R9
    '{OP_RD,  6'h04, 8'h00, 1'b0, 8'h78, 1'b0, 2'd0, 2'd1, 4'd10}, // R10
    '{OP_SWR, 6'h04, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7},  // R7
    '{OP_RD,  6'h04, 8'h00, 1'b0, 8'h78, 1'b0, 2'd0, 2'd1, 4'd7},  // R7
    '{OP_WR,  6'h09, 8'h33, 1'b0, 8'h00, 1'b0, 2'd1, 2'd0, 4'd4},  // R4 miss
    '{OP_SWR, 6'h09, 8'h00, 1'b0, 8'h33, 1'b1, 2'd0, 2'd0, 4'd6},  // R6 write
    '{OP_RD,  6'h09, 8'h00, 1'b0, 8'h33, 1'b0, 2'd0, 2'd1, 4'd6},  // R6
    '{OP_SRD, 6'h0D, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd3},  // R3 tag miss
    '{OP_WR,  6'h0A, 8'h44, 1'b0, 8'h00, 1'b0, 2'd1, 2'd0, 4'd4},  // R4
    '{OP_WR,  6'h0E, 8'h55, 1'b0, 8'h00, 1'b0, 2'd2, 2'd0, 4'd9},  // R9
    '{OP_RD,  6'h0A, 8'h00, 1'b0, 8'h44, 1'b0, 2'd1, 2'd1, 4'd9},  // R9
    '{OP_RD,  6'h0E, 8'h00, 1'b0, 8'h55, 1'b0, 2'd0, 2'd1, 4'd10}  // R10
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata;
  logic          cpuDone, busReq, busWr;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busAck = 1'b0;
  logic [DW-1:0] busRdata = '0;
  logic          busFromCache = 1'b0;
  logic          snpValid = 1'b0, snpWr = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpInhibit;
  logic [DW-1:0] snpData;

  logic [DW-1:0] mem [1<<AW];
  int            wrCnt = 0, rdCnt = 0;
  logic          fromC = 1'b0;
  logic [DW-1:0] supply = '0;
  int            checks = 0, fails = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .busReq(busReq), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busFromCache(busFromCache),
    .snpValid(snpValid), .snpWr(snpWr), .snpAddr(snpAddr),
    .snpInhibit(snpInhibit), .snpData(snpData)
  );

  initial for (int a = 0; a < (1 << AW); a++) mem[a] = DW'(a) ^ 8'h5A;

  // memory and remote-cache model: answers each request in its cycle
  always @(negedge clk) begin
    #0.5;
    if (busReq) begin
      busAck = 1'b1;
      if (busWr) begin
        mem[busAddr] = busWdata;
        wrCnt++;
        busFromCache = 1'b0;
      end else begin
        busRdata     = fromC ? supply : mem[busAddr];
        busFromCache = fromC;
        rdCnt++;
      end
    end else begin
      busAck       = 1'b0;
      busFromCache = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitDone(output logic [DW-1:0] rd);
    rd = '0;
    for (int c = 0; c < 20; c++) begin
      #1;
      if (cpuDone) begin
        rd = cpuRdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic cpuOp(input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    waitDone(rd);
  endtask

  task automatic snoopOp(input logic wr, input logic [AW-1:0] a,
                         output logic inh, output logic [DW-1:0] sd);
    snpValid = 1'b1; snpWr = wr; snpAddr = a;
    #1;
    inh = snpInhibit;
    sd  = snpData;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd, sd;
    logic          inh;
    int            w0, r0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 idle outputs after reset
    check(!busReq && !cpuDone && !snpInhibit, "R1", "idle outputs",
          {busReq, cpuDone, snpInhibit}, 0);
    @(negedge clk);
    w0 = wrCnt; r0 = rdCnt;
    cpuOp(1'b0, 6'h00, 8'h00, rd);
    // R1 first read misses
    check(rd == 8'h5A && rdCnt - r0 == 1 && wrCnt == w0, "R1", "first read",
          {rd, 8'(rdCnt - r0)}, {8'h5A, 8'd1});

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [DW-1:0] gotD;
      logic          gotF;
      v = VECS[i];
      w0 = wrCnt; r0 = rdCnt;
      fromC = v.fromC; supply = v.data;
      gotD = '0; gotF = 1'b0;
      case (v.op)
        OP_RD:  cpuOp(1'b0, v.addr, v.data, gotD);
        OP_WR:  cpuOp(1'b1, v.addr, v.data, rd);
        OP_SRD: begin snoopOp(1'b0, v.addr, gotF, gotD); if (!v.expFlag) gotD = '0; end
        default: begin snoopOp(1'b1, v.addr, gotF, gotD); if (!v.expFlag) gotD = '0; end
      endcase
      fromC = 1'b0;
      check({gotD, gotF, 2'(wrCnt - w0), 2'(rdCnt - r0)} ==
            {v.expData, v.expFlag, v.expWr, v.expRd},
            $sformatf("R%0d", v.req), $sformatf("vector %0d", i),
            {gotD, gotF, 2'(wrCnt - w0), 2'(rdCnt - r0)},
            {v.expData, v.expFlag, v.expWr, v.expRd});
    end

    // R11 snoop priority over a pending write-back
    w0 = wrCnt;
    cpuOp(1'b1, 6'h03, 8'h66, rd);
    check(wrCnt - w0 == 1, "R4", "write miss slot 3", wrCnt - w0, 1);
    w0 = wrCnt; r0 = rdCnt;
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 6'h07;
    @(negedge clk);
    snpValid = 1'b1; snpWr = 1'b0; snpAddr = 6'h03;
    #1;
    check(!busReq && snpInhibit && snpData == 8'h66, "R11", "bus held off by dirty snoop",
          {busReq, snpInhibit, snpData}, {1'b0, 1'b1, 8'h66});
    @(negedge clk);
    snpValid = 1'b0;
    waitDone(rd);
    check(rd == 8'h5D && wrCnt == w0 && rdCnt - r0 == 1, "R11", "write-back dropped",
          {rd, 8'(wrCnt - w0)}, {8'h5D, 8'd0});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule